// File: doc/BRIEF.md
# Serial frequency word loader

This block takes a 16-bit frequency word from a three-line serial link (serial clock, serial data and a latch strobe) and presents it as a stable, double-buffered word to a phase accumulator running in the system clock domain. All three serial lines are brought into the system clock domain through two-flop synchronizers. Edges of the serial clock and the strobe are then found by comparing each synchronized level with its value one cycle earlier. Because sampling happens in the system clock domain, the system clock must run at least four times faster than the fastest serial edge rate.

Each rising edge of the serial clock shifts one data bit into a shift register, least significant bit first. A falling edge of the strobe copies the whole shift register into the holding latch that drives the accumulator. While the strobe is high and the shift register holds all zeros, the block raises a power-down flag instead of treating the zero word as a frequency. The flag clears once the strobe goes low or a nonzero bit enters the shift register.

The frequency word is a held register that the accumulator reads on every cycle, so it has no valid/ready handshake and no back-pressure. A new value simply replaces the old one three cycles after the strobe falls. The power-down flag is a plain level output.

Top module: `sfw_loader`

## Requirements
- R1: After reset, `freq_word_o` is 0 and `pwr_down_o` is 0.
- R2: A word sent as 16 serial bits, bit 0 first and bit 15 last, each bit taken on a rising edge of `ser_clk_i`, appears on `freq_word_o` with its bit order preserved after a falling edge of `ser_lat_i`. This holds for all-zero and all-one words as well.
- R3: `freq_word_o` changes on the third rising system clock edge after `ser_lat_i` falls. Through the second edge it still shows the previous word.
- R4: Shifting in a new word, and a rising edge of `ser_lat_i`, leave `freq_word_o` unchanged. Only the next falling edge of the strobe loads the new word.
- R5: When more than 16 bits are shifted before the strobe falls, the latch receives the last 16 bits sent. The most recent bit is in bit 15.
- R6: Holding `ser_clk_i` high for many system cycles shifts exactly one bit. Shifting happens on edges, not on levels.
- R7: With an all-zero shift register, `pwr_down_o` rises on the second rising system clock edge after `ser_lat_i` rises. It stays high while both conditions hold.
- R8: With power-down active, `pwr_down_o` clears on the second rising system clock edge after `ser_lat_i` falls.
- R9: With power-down active and the strobe still high, shifting in a 1 clears `pwr_down_o` on the third rising system clock edge after that `ser_clk_i` rising edge.
- R10: `pwr_down_o` stays 0 while `ser_lat_i` is low, even when the shift register holds all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial edge rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| ser_lat_i | input | 1 | Latch strobe; its falling edge commits the word, and held high over zero data it requests power-down |
| freq_word_o | output | 16 | Held frequency word for the phase accumulator |
| pwr_down_o | output | 1 | Power-down request |

## Verification
Every serial line passes through two synchronizer flops. An edge is therefore seen one cycle after the synchronized level changes, and a state update caused by that edge lands on the third system clock edge after the input changes. This covers the shift register and the word latch. The power-down flag reads the synchronized strobe level directly, so it follows the strobe on the second edge, and it follows a shift of a 1 on the third edge. The bench drives every input at the falling system clock edge and counts rising edges one at a time before sampling at the next falling edge. It checks the cycle just before each due result, where the old value must still be present, and then the cycle the new value is due. Scenarios that only check end values wait well past these latencies before sampling.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  // Width of the frequency word carried over the serial link.
  parameter int unsigned SFW_WORD_W = 16;
  // Synchronizer depth applied to every serial line.
  parameter int unsigned SFW_SYNC_STAGES = 2;

  // Position of each serial line inside the synchronized bundle.
  typedef enum logic [1:0] {
    LINE_SCK = 2'd0,
    LINE_DAT = 2'd1,
    LINE_LAT = 2'd2
  } sfw_line_e;

  localparam int unsigned SFW_LINES = 3;
endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);
  logic [LINES-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/sfw_edge.sv
module sfw_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  if (FALLING) begin : g_fall
    assign edge_o = prev_q & ~lvl_i;
  end else begin : g_rise
    assign edge_o = lvl_i & ~prev_q;
  end
endmodule

// File: rtl/sfw_shift.sv
module sfw_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sh_o,
  output logic         zero_o
);
  logic [W-1:0] sh_q;

  // New bits enter at the top, so the first bit sent ends up in bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[W-1:1]};
  end

  assign sh_o   = sh_q;
  assign zero_o = (sh_q == '0);
endmodule

// File: rtl/sfw_hold.sv
module sfw_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         zero_i,
  input  logic         lat_lvl_i,
  output logic [W-1:0] word_o,
  output logic         pd_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign word_o = word_q;
  // Power-down follows the level of the strobe, so it clears as soon as either condition ends.
  assign pd_o   = lat_lvl_i & zero_i;
endmodule

// File: rtl/sfw_loader.sv
module sfw_loader
  import sfw_pkg::*;
#(
  parameter int unsigned WORD_W      = SFW_WORD_W,
  parameter int unsigned SYNC_STAGES = SFW_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_lat_i,
  output logic [WORD_W-1:0] freq_word_o,
  output logic              pwr_down_o
);
  logic [SFW_LINES-1:0] raw;
  logic [SFW_LINES-1:0] lvl;
  logic                 sck_rise;
  logic                 lat_fall;
  logic [WORD_W-1:0]    shreg;
  logic                 sh_zero;

  assign raw[LINE_SCK] = ser_clk_i;
  assign raw[LINE_DAT] = ser_dat_i;
  assign raw[LINE_LAT] = ser_lat_i;

  sfw_sync #(.LINES(SFW_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(lvl)
  );

  sfw_edge #(.FALLING(1'b0)) sck_edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[LINE_SCK]), .edge_o(sck_rise)
  );

  sfw_edge #(.FALLING(1'b1)) lat_edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[LINE_LAT]), .edge_o(lat_fall)
  );

  sfw_shift #(.W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_i(sck_rise), .bit_i(lvl[LINE_DAT]),
    .sh_o(shreg), .zero_o(sh_zero)
  );

  sfw_hold #(.W(WORD_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .load_i(lat_fall), .word_i(shreg),
    .zero_i(sh_zero), .lat_lvl_i(lvl[LINE_LAT]),
    .word_o(freq_word_o), .pd_o(pwr_down_o)
  );
endmodule

// File: rtl/sfw_loader_chk.sv
module sfw_loader_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_lat_i,
  input logic [W-1:0] freq_word_o,
  input logic         pwr_down_o,
  input logic         sck_rise,
  input logic         lat_fall,
  input logic [W-1:0] shreg
);
  // R2: a strobe fall commits the shift register contents
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fall |=> (freq_word_o == $past(shreg)));

  // R4: without a strobe fall the held word never moves
  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_fall |=> $stable(freq_word_o));

  // R6: the shift register moves only on a detected serial clock edge
  p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(shreg));

  // R7: power-down implies an empty shift register
  p_pd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_o |-> (shreg == '0));

  // R10: power-down implies the strobe was high two cycles earlier
  p_pd_lat_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_o |-> $past(ser_lat_i, 2));
endmodule

bind sfw_loader sfw_loader_chk #(.W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_lat_i(ser_lat_i),
  .freq_word_o(freq_word_o), .pwr_down_o(pwr_down_o),
  .sck_rise(sck_rise), .lat_fall(lat_fall), .shreg(shreg)
);

// File: tb/sfw_loader_tb_top.sv
module sfw_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk_i = 1'b0;
  logic        ser_dat_i = 1'b0;
  logic        ser_lat_i = 1'b0;
  logic [15:0] freq_word_o;
  logic        pwr_down_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sfw_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .ser_lat_i(ser_lat_i), .freq_word_o(freq_word_o), .pwr_down_o(pwr_down_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int hi_len);
    ser_dat_i = b;
    ser_clk_i = 1'b0;
    tick(4);
    ser_clk_i = 1'b1;
    tick(hi_len);
    ser_clk_i = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i], 4);
    tick(4);
  endtask

  task automatic strobe();
    ser_lat_i = 1'b1;
    tick(4);
    ser_lat_i = 1'b0;
    tick(8);
  endtask

  task automatic t_reset_r1();
    tick(2);
    chk("R1 word after reset", freq_word_o, 16'h0000);
    chk("R1 pd after reset", {15'd0, pwr_down_o}, 16'h0000);
  endtask

  task automatic t_basic_r2();
    logic [15:0] pats [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF};
    for (int k = 0; k < 4; k++) begin
      send_bits({16'd0, pats[k]}, 16);
      strobe();
      chk("R2 loaded word", freq_word_o, pats[k]);
    end
  endtask

  task automatic t_latency_r3();
    logic [15:0] old_w;
    old_w = freq_word_o;
    send_bits(32'h1234, 16);
    ser_lat_i = 1'b1;
    tick(4);
    ser_lat_i = 1'b0;
    tick(2);
    chk("R3 word two edges after fall", freq_word_o, old_w);
    tick(1);
    chk("R3 word three edges after fall", freq_word_o, 16'h1234);
    tick(6);
  endtask

  task automatic t_double_r4();
    send_bits(32'hBEEF, 16);
    chk("R4 word after shifting only", freq_word_o, 16'h1234);
    ser_lat_i = 1'b1;
    tick(6);
    chk("R4 word after strobe rise", freq_word_o, 16'h1234);
    ser_lat_i = 1'b0;
    tick(4);
    chk("R4 word after strobe fall", freq_word_o, 16'hBEEF);
  endtask

  task automatic t_overrun_r5();
    send_bits(32'h000F_0A5C, 20);
    strobe();
    chk("R5 last sixteen bits kept", freq_word_o, 16'hF0A5);
  endtask

  task automatic t_level_r6();
    logic [15:0] v;
    v = 16'h6B1D;
    for (int i = 0; i < 16; i++) send_bit(v[i], (i == 7) ? 40 : 4);
    tick(4);
    strobe();
    chk("R6 long high phase shifts once", freq_word_o, v);
  endtask

  task automatic t_pd_r7_r8();
    send_bits(32'h0, 16);
    chk("R10 pd low with zero register and strobe low", {15'd0, pwr_down_o}, 16'h0000);
    ser_lat_i = 1'b1;
    tick(1);
    chk("R7 pd one edge after strobe rise", {15'd0, pwr_down_o}, 16'h0000);
    tick(1);
    chk("R7 pd two edges after strobe rise", {15'd0, pwr_down_o}, 16'h0001);
    tick(10);
    chk("R7 pd held", {15'd0, pwr_down_o}, 16'h0001);
    ser_lat_i = 1'b0;
    tick(1);
    chk("R8 pd one edge after strobe fall", {15'd0, pwr_down_o}, 16'h0001);
    tick(1);
    chk("R8 pd two edges after strobe fall", {15'd0, pwr_down_o}, 16'h0000);
    tick(2);
    chk("R2 zero word loaded on fall", freq_word_o, 16'h0000);
  endtask

  task automatic t_pd_release_r9();
    send_bits(32'h0, 16);
    ser_lat_i = 1'b1;
    tick(4);
    chk("R7 pd before release", {15'd0, pwr_down_o}, 16'h0001);
    ser_dat_i = 1'b1;
    tick(2);
    ser_clk_i = 1'b1;
    tick(2);
    chk("R9 pd two edges after shift", {15'd0, pwr_down_o}, 16'h0001);
    tick(1);
    chk("R9 pd three edges after shift", {15'd0, pwr_down_o}, 16'h0000);
    ser_clk_i = 1'b0;
    tick(4);
    ser_lat_i = 1'b0;
    tick(8);
    chk("R2 single top bit loaded", freq_word_o, 16'h8000);
    chk("R10 pd low after strobe low", {15'd0, pwr_down_o}, 16'h0000);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset_r1();
    t_basic_r2();
    t_latency_r3();
    t_double_r4();
    t_overrun_r5();
    t_level_r6();
    t_pd_r7_r8();
    t_pd_release_r9();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule